// File: doc/BRIEF.md
# Channel Clock Divider with Duty-Cycle Correction

This block divides an input clock by a programmable integer ratio. Two 4-bit count fields set the two phases separately. The high count sets how many input cycles the output stays high, and the low count does the same for the low phase. One output period is therefore high count plus low count plus two input cycles long. The shortest period is 2 cycles and the longest is 32.

A correction path gives a 50% output for odd ratios. It does this when the low count is exactly one more than the high count. The high phase is then held for an extra half input cycle by a flop clocked on the falling edge. Correction is active when its disable bit is low. It leaves even ratios untouched. A bypass bit sends the input clock straight to the output and overrides every other setting.

The divider is configured while the block is held in reset. It starts cleanly on the first rising input edge after reset is released.

Top module: `chan_clkdiv`

## Requirements
- R1: The output period is hi_cnt_i + lo_cnt_i + 2 input clock cycles. Both fields are 4-bit unsigned values (0 to 15).
- R2: With dcc_off_i = 1 and bypass_i = 0, the output is high for hi_cnt_i + 1 input cycles and low for lo_cnt_i + 1 input cycles in each period.
- R3: Correction is active when dcc_off_i = 0, so the level that reset and default wiring give (0) enables it.
- R4: For an even total ratio (hi_cnt_i and lo_cnt_i of equal parity), the correction setting does not change the waveform. The output is high for hi_cnt_i + 1 cycles and low for lo_cnt_i + 1 cycles.
- R5: With correction active, lo_cnt_i = hi_cnt_i + 1 and a 50% input, the high time becomes hi_cnt_i + 1.5 cycles and the low time lo_cnt_i + 0.5 cycles. The extra half cycle comes from the falling input edge, which gives exactly 50%.
- R6: With correction active and an odd ratio where lo_cnt_i ≠ hi_cnt_i + 1, no stretch is applied and the R2 timing is produced.
- R7: With bypass_i = 1, clk_o follows clk_i (ratio 1, input duty kept) whatever the value of dcc_off_i.
- R8: While rst_ni is low, clk_o is low when bypass_i = 0. After release, clk_o goes high at the first rising edge of clk_i and the high phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_cnt_i | input | 4 | High-phase count; high time is this value + 1 cycles |
| lo_cnt_i | input | 4 | Low-phase count; low time is this value + 1 cycles |
| dcc_off_i | input | 1 | 1 disables duty-cycle correction |
| bypass_i | input | 1 | 1 routes clk_i directly to clk_o |
| clk_o | output | 1 | Divided, optionally corrected, output clock |

## Verification
The hardest effect to observe is the half-cycle stretch. It moves one output edge to a falling input edge, so sampling once per input cycle cannot see it. The bench therefore samples clk_o in the middle of every half cycle, giving one sample per half cycle. It then measures the high and low times in half-cycle units. Every pair of count values is run with correction both on and off, so all odd ratios are covered. That includes the ratios where the stretch must appear and those where it must not.

// File: rtl/chan_clkdiv_pkg.sv
package chan_clkdiv_pkg;

    // Phase of the rising-edge counter
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/chan_clkdiv_count.sv
module chan_clkdiv_count
    import chan_clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    output logic             level_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IDLE: begin
                s_d.phase = PH_HIGH;
                s_d.cnt   = '0;
            end
            PH_HIGH: begin
                if (s_q.cnt == hi_cnt_i) begin
                    s_d.phase = PH_LOW;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_ONE;
                end
            end
            PH_LOW: begin
                if (s_q.cnt == lo_cnt_i) begin
                    s_d.phase = PH_HIGH;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_ONE;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
                s_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = (s_q.phase == PH_HIGH);

    // R2
    hi_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_HIGH) |-> (s_q.cnt <= hi_cnt_i));

    // R1
    lo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_LOW) |-> (s_q.cnt <= lo_cnt_i));

    // R8
    first_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_IDLE) |=> level_o);

endmodule

// File: rtl/chan_clkdiv_decode.sv
module chan_clkdiv_decode #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic             dcc_off_i,
    output logic             stretch_en_o
);

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] hi_plus_one;

    always_comb begin
        hi_plus_one  = {1'b0, hi_cnt_i} + EXT_W'(1);
        // Correction only when the low count leads the high count by one
        stretch_en_o = !dcc_off_i && ({1'b0, lo_cnt_i} == hi_plus_one);
    end

endmodule

// File: rtl/chan_clkdiv_stretch.sv
module chan_clkdiv_stretch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic stretch_en_i,
    output logic shaped_o
);

    logic hold_d, hold_q;

    always_comb begin
        hold_d = level_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign shaped_o = level_i | (stretch_en_i & hold_q);

endmodule

// File: rtl/chan_clkdiv.sv
module chan_clkdiv #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic             dcc_off_i,
    input  logic             bypass_i,
    output logic             clk_o
);

    logic level;
    logic stretch_en;
    logic shaped;

    chan_clkdiv_count #(.CNT_W(CNT_W)) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hi_cnt_i (hi_cnt_i),
        .lo_cnt_i (lo_cnt_i),
        .level_o  (level)
    );

    chan_clkdiv_decode #(.CNT_W(CNT_W)) u_decode (
        .hi_cnt_i     (hi_cnt_i),
        .lo_cnt_i     (lo_cnt_i),
        .dcc_off_i    (dcc_off_i),
        .stretch_en_o (stretch_en)
    );

    chan_clkdiv_stretch u_stretch (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .level_i      (level),
        .stretch_en_i (stretch_en),
        .shaped_o     (shaped)
    );

    assign clk_o = bypass_i ? clk_i : shaped;

    // R4
    even_no_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_cnt_i[0] == lo_cnt_i[0]) |-> !stretch_en);

endmodule

// File: tb/chan_clkdiv_tb.sv
`timescale 1ns/1ps
module chan_clkdiv_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] n_cfg = '0;
    logic [3:0] m_cfg = '0;
    logic       off_cfg = 1'b0;
    logic       byp_cfg = 1'b0;
    logic       clk_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    chan_clkdiv u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .hi_cnt_i  (n_cfg),
        .lo_cnt_i  (m_cfg),
        .dcc_off_i (off_cfg),
        .bypass_i  (byp_cfg),
        .clk_o     (clk_out)
    );

    // {n[21:18], m[17:14], dcc_off[13], bypass[12], hi_half[11:6], lo_half[5:0]}
    localparam int NV = 14;
    localparam logic [21:0] VEC [NV] = '{
        {4'd0,  4'd0,  1'b0, 1'b0, 6'd2,  6'd2 },
        {4'd1,  4'd1,  1'b0, 1'b0, 6'd4,  6'd4 },
        {4'd0,  4'd1,  1'b0, 1'b0, 6'd3,  6'd3 },
        {4'd0,  4'd1,  1'b1, 1'b0, 6'd2,  6'd4 },
        {4'd3,  4'd4,  1'b0, 1'b0, 6'd9,  6'd9 },
        {4'd3,  4'd4,  1'b1, 1'b0, 6'd8,  6'd10},
        {4'd2,  4'd5,  1'b0, 1'b0, 6'd6,  6'd12},
        {4'd5,  4'd2,  1'b0, 1'b0, 6'd12, 6'd6 },
        {4'd7,  4'd3,  1'b0, 1'b0, 6'd16, 6'd8 },
        {4'd14, 4'd15, 1'b0, 1'b0, 6'd31, 6'd31},
        {4'd15, 4'd15, 1'b1, 1'b0, 6'd32, 6'd32},
        {4'd6,  4'd9,  1'b0, 1'b1, 6'd1,  6'd1 },
        {4'd6,  4'd7,  1'b1, 1'b1, 6'd1,  6'd1 },
        {4'd4,  4'd4,  1'b1, 1'b0, 6'd10, 6'd10}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance one half cycle; samples land midway between clock edges
    task automatic half(output logic v);
        #2;
        v = clk_out;
    endtask

    task automatic start(input logic [3:0] n, input logic [3:0] m,
                         input logic off, input logic byp);
        logic v;
        rst_n   = 1'b0;
        n_cfg   = n;
        m_cfg   = m;
        off_cfg = off;
        byp_cfg = byp;
        half(v);
        half(v);
        if (($time % 4) != 1) half(v);
        rst_n = 1'b1;
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev, v;
        int guard;
        hi = -1;
        lo = -1;
        guard = 0;
        half(prev);
        half(v);
        while (!(prev == 1'b0 && v == 1'b1) && guard < 200) begin
            prev = v;
            half(v);
            guard++;
        end
        if (guard >= 200) return;
        hi = 0;
        while (v == 1'b1 && hi < 100) begin hi++; half(v); end
        lo = 0;
        while (v == 1'b0 && lo < 100) begin lo++; half(v); end
    endtask

    initial begin
        logic v;
        int hi, lo;
        #1;

        // R8: reset holds output low, first rising edge drives it high
        rst_n = 1'b0; byp_cfg = 1'b0; off_cfg = 1'b0; n_cfg = 4'd2; m_cfg = 4'd3;
        half(v);
        half(v);
        if (($time % 4) != 1) half(v);
        check(clk_out == 1'b0, "R8", "low in reset", clk_out, 0);
        half(v);
        check(v == 1'b0, "R8", "low in reset after edge", v, 0);
        half(v);
        rst_n = 1'b1;
        check(clk_out == 1'b0, "R8", "low just after release", clk_out, 0);
        half(v);
        check(v == 1'b1, "R8", "high after first rising edge", v, 1);

        // Table of directed vectors
        for (int i = 0; i < NV; i++) begin
            logic [3:0] n, m;
            logic off, byp;
            int ehi, elo;
            string tag;
            n   = VEC[i][21:18];
            m   = VEC[i][17:14];
            off = VEC[i][13];
            byp = VEC[i][12];
            ehi = int'(VEC[i][11:6]);
            elo = int'(VEC[i][5:0]);
            if (byp)                            tag = "R7";
            else if (off)                       tag = "R2";
            else if (n[0] == m[0])              tag = "R4";
            else if ({1'b0, m} == {1'b0, n} + 5'd1) tag = "R5,R3";
            else                                tag = "R6";
            start(n, m, off, byp);
            measure(hi, lo);
            check(hi == ehi, tag, $sformatf("vec %0d high half-cycles", i), hi, ehi);
            check(lo == elo, tag, $sformatf("vec %0d low half-cycles", i), lo, elo);
        end

        // Sweep of every count pair with correction on and off
        for (int n = 0; n < 16; n++) begin
            for (int m = 0; m < 16; m++) begin
                for (int off = 0; off < 2; off++) begin
                    bit st;
                    int ehi, elo;
                    string tag;
                    st  = (off == 0) && (m == n + 1);
                    ehi = 2 * (n + 1) + (st ? 1 : 0);
                    elo = 2 * (m + 1) - (st ? 1 : 0);
                    if (off == 1)                 tag = "R2";
                    else if (st)                  tag = "R5";
                    else if (((n + m) % 2) == 0)  tag = "R4";
                    else                          tag = "R6";
                    start(4'(n), 4'(m), 1'(off), 1'b0);
                    measure(hi, lo);
                    check(hi == ehi, tag, $sformatf("n=%0d m=%0d off=%0d high", n, m, off), hi, ehi);
                    check(lo == elo, tag, $sformatf("n=%0d m=%0d off=%0d low", n, m, off), lo, elo);
                    check(hi + lo == 2 * (n + m + 2), "R1",
                          $sformatf("n=%0d m=%0d off=%0d period", n, m, off),
                          hi + lo, 2 * (n + m + 2));
                end
            end
        end

        // R7: bypass follows the input clock sample by sample, correction ignored
        start(4'd9, 4'd10, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) begin
            half(v);
            check(v == clk, "R7", "bypass follows clk", v, clk);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule